// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block sits between a 16-bit CPU bus and a small embedded flash array. Software arms an operation by writing a four-bit mode value into the control port. It then starts that operation by writing to a flash address on the bus. When an erase mode is armed, the write only serves as a trigger and its address picks what gets erased. When the write mode is armed, the write's data is programmed into the addressed cell. Programming can only pull bits from 1 to 0, and erasing returns a whole segment, or a larger region, to all ones.

While an operation runs the block holds `busy_o` high and counts its duration in flash-clock ticks. The ticks come from a divider set by `div_i`, so every tick lasts `div_i+1` clock cycles. At the end of an erase the block clears its erase mode bits by itself. Block programming is paced one word at a time: `wait_o` tells software when the next word may be written. While the block is busy, an instruction fetch from flash returns the jump-to-self opcode, so a CPU running from flash simply spins. A data access to flash, or an illegal control write, raises a sticky violation flag. An abort input stops any operation at once.

The address map has two parts. Information segments of `INFO_SEG_BYTES` each start at `INFO_BASE`. Main segments of `MAIN_SEG_BYTES` (512 by default) fill the top of the address space. With the default parameters the main array covers 0xF800 to 0xFFFF in four segments, and the information area covers 0x1000 to 0x10FF in two 128-byte segments.

Top module: `flashseq_ctrl`

## Requirements
- R1: Control bits are: bit0 write, bit1 block, bit2 erase, bit3 mass. With erase=1 and mass=0, a bus write to any flash address erases only the segment that holds that address, setting its words to 0xFFFF. Every other segment keeps its contents.
- R2: With mass=1 and erase=0, a bus write to a main-array address erases every main segment and leaves the information segments unchanged. A write to an information address in this mode is ignored.
- R3: With mass=1 and erase=1, a bus write to any flash address erases both the main and the information segments.
- R4: When an erase mode is armed, a bus write to a non-flash address is ignored: `busy_o` stays low and the control bits keep their value.
- R5: `busy_o` rises at the clock edge that samples the triggering write. It stays high for exactly ERASE_TICKS*(div_i+1) cycles for an erase, and for WORD_TICKS*(div_i+1) cycles for a single word or byte write. When an erase ends, the erase and mass bits read 0. When a single write ends, the write bit stays set.
- R6: Programming stores old AND new. A byte write (`bus_byte_i`=1) takes its data from `bus_wdata_i[7:0]` and targets the low byte when address bit0 is 0, or the high byte when it is 1. The other byte is left unchanged. No bit ever changes from 0 to 1.
- R7: With write=1 and block=1, each word keeps `wait_o` low for BLK_TICKS*(div_i+1) cycles, and then `wait_o` rises to accept the next word. After BLK_BYTES/2 words (32 by default), `busy_o` and `wait_o` fall by themselves. A control write that clears the write or block bit while `wait_o` is high ends the run on the next cycle, without a violation.
- R8: While `busy_o` is high, an instruction fetch from a flash address returns 0x3FFF and does not raise `acc_viol_o`.
- R9: While `busy_o` is high, a data read of flash, or a data write to flash outside an accepted block word, sets `acc_viol_o`. Such a write does not change the array, and the running operation completes. `acc_clr_i` clears the flag.
- R10: While `busy_o` is high and `wait_o` is low, a control write is ignored and sets `acc_viol_o`.
- R11: `abort_i` returns the block to idle on the next cycle, with `busy_o`, `wait_o` and all control bits at 0. The aborted operation leaves the array unchanged.
- R12: After reset, `busy_o`, `wait_o` and `acc_viol_o` are 0, the control bits are 0, and every flash word reads 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_i | input | DIV_W | Flash tick divider; one tick every div_i+1 cycles |
| ctl_we_i | input | 1 | Control write strobe |
| ctl_wdata_i | input | 4 | Control value {mass, erase, block, write} |
| ctl_o | output | 4 | Current control bits |
| abort_i | input | 1 | Emergency stop pulse |
| bus_req_i | input | 1 | Bus access valid |
| bus_we_i | input | 1 | Bus access is a write |
| bus_fetch_i | input | 1 | Bus read is an instruction fetch |
| bus_byte_i | input | 1 | Bus write is a byte write |
| bus_addr_i | input | AW | Byte address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data (combinational) |
| busy_o | output | 1 | Operation in progress |
| wait_o | output | 1 | Block mode ready for the next word |
| acc_viol_o | output | 1 | Sticky access-violation flag |
| acc_clr_i | input | 1 | Clears the violation flag |

## Verification
The programming path is tried with a table of word and byte writes. The entries repeat addresses, use both byte lanes, and pair data with bits already cleared, so a design that overwrites, ORs, or uses the wrong lane gives a readback that differs from the AND result. Each entry uses a different divider, and the bench measures the length of `busy_o` against the tick formula, which catches an off-by-one in the divider or the tick counter. The three erase modes are each triggered from an address chosen so that segment, main-only and full erase leave different survivors in the main and information areas. Trigger addresses that a given mode must ignore are also tried. Fetches, data accesses and control writes are then issued while an erase runs, to separate the jump-to-self path from the violation path, and both block-end conditions and the abort are run.

// File: rtl/flashseq_pkg.sv
`timescale 1ns/1ps
package flashseq_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ERASE,
      ST_WORD,
      ST_BLK_RUN,
      ST_BLK_WAIT
   } seq_state_e;

   localparam int CTL_BITS = 4;
   localparam int CB_PROG  = 0;
   localparam int CB_BLK   = 1;
   localparam int CB_ERASE = 2;
   localparam int CB_MASS  = 3;

   localparam logic [15:0] JMP_SELF = 16'h3FFF;
endpackage

// File: rtl/flashseq_tickgen.sv
`timescale 1ns/1ps
module flashseq_tickgen #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt_q;

   if (DIV_W < 1) begin : g_bad_div
      $error("DIV_W must be at least 1");
   end

   assign tick = en && (cnt_q == div);

   // counter restarts whenever the sequencer is not counting, so the
   // first tick of an operation lands exactly div+1 cycles after start
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!en || tick)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/flashseq_decode.sv
`timescale 1ns/1ps
module flashseq_decode #(
   parameter int AW             = 16,
   parameter int INFO_BASE      = 4096,
   parameter int INFO_SEG_BYTES = 128,
   parameter int INFO_SEGS      = 2,
   parameter int MAIN_SEG_BYTES = 512,
   parameter int MAIN_SEGS      = 4,
   parameter int SEG_W          = 3,
   parameter int OFF_W          = 8
) (
   input  logic [AW-1:0]    addr,
   output logic             hit,
   output logic             is_main,
   output logic [SEG_W-1:0] seg,
   output logic [OFF_W-1:0] off
);
   localparam int INFO_END  = INFO_BASE + INFO_SEGS * INFO_SEG_BYTES;
   localparam int MAIN_BASE = (1 << AW) - MAIN_SEGS * MAIN_SEG_BYTES;

   if (INFO_END > MAIN_BASE) begin : g_bad_map
      $error("information area overlaps the main array");
   end

   int ai;
   logic in_info;

   always_comb begin
      ai      = int'(addr);
      in_info = (ai >= INFO_BASE) && (ai < INFO_END);
      is_main = (ai >= MAIN_BASE);
      hit     = in_info || is_main;
      seg     = '0;
      off     = '0;
      if (is_main) begin
         seg = SEG_W'(INFO_SEGS + (ai - MAIN_BASE) / MAIN_SEG_BYTES);
         off = OFF_W'(((ai - MAIN_BASE) % MAIN_SEG_BYTES) / 2);
      end else if (in_info) begin
         seg = SEG_W'((ai - INFO_BASE) / INFO_SEG_BYTES);
         off = OFF_W'(((ai - INFO_BASE) % INFO_SEG_BYTES) / 2);
      end
   end
endmodule

// File: rtl/flashseq_array.sv
`timescale 1ns/1ps
module flashseq_array #(
   parameter int INFO_SEGS      = 2,
   parameter int INFO_SEG_WORDS = 64,
   parameter int MAIN_SEGS      = 4,
   parameter int MAIN_SEG_WORDS = 256,
   parameter int SEG_W          = 3,
   parameter int OFF_W          = 8,
   localparam int NSEG          = INFO_SEGS + MAIN_SEGS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             erase_go,
   input  logic [NSEG-1:0]  erase_mask,
   input  logic             prog_go,
   input  logic [SEG_W-1:0] prog_seg,
   input  logic [OFF_W-1:0] prog_off,
   input  logic [15:0]      prog_pat,
   input  logic [SEG_W-1:0] rd_seg,
   input  logic [OFF_W-1:0] rd_off,
   output logic [15:0]      rd_word
);
   logic [15:0] seg_rd [NSEG];

   for (genvar s = 0; s < NSEG; s++) begin : g_seg
      // information and main segments differ in depth
      localparam int WORDS = (s < INFO_SEGS) ? INFO_SEG_WORDS : MAIN_SEG_WORDS;
      localparam int LW    = $clog2(WORDS);

      logic [15:0]   mem [WORDS];
      logic [LW-1:0] p_idx;
      logic [LW-1:0] r_idx;

      assign p_idx     = prog_off[LW-1:0];
      assign r_idx     = rd_off[LW-1:0];
      assign seg_rd[s] = mem[r_idx];

      // cells only move toward 1 by erase and toward 0 by program (R6)
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int w = 0; w < WORDS; w++) mem[w] <= '1;
         end else if (erase_go && erase_mask[s]) begin
            for (int w = 0; w < WORDS; w++) mem[w] <= '1;
         end else if (prog_go && (prog_seg == SEG_W'(s))) begin
            mem[p_idx] <= mem[p_idx] & prog_pat;
         end
      end
   end

   assign rd_word = (int'(rd_seg) < NSEG) ? seg_rd[rd_seg] : '1;
endmodule

// File: rtl/flashseq_ctrl.sv
`timescale 1ns/1ps
module flashseq_ctrl
   import flashseq_pkg::*;
#(
   parameter int AW             = 16,
   parameter int DIV_W          = 8,
   parameter int INFO_BASE      = 4096,
   parameter int INFO_SEG_BYTES = 128,
   parameter int INFO_SEGS      = 2,
   parameter int MAIN_SEG_BYTES = 512,
   parameter int MAIN_SEGS      = 4,
   parameter int ERASE_TICKS    = 20,
   parameter int WORD_TICKS     = 6,
   parameter int BLK_TICKS      = 3,
   parameter int BLK_BYTES      = 64
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [DIV_W-1:0]    div_i,
   input  logic                ctl_we_i,
   input  logic [CTL_BITS-1:0] ctl_wdata_i,
   output logic [CTL_BITS-1:0] ctl_o,
   input  logic                abort_i,
   input  logic                bus_req_i,
   input  logic                bus_we_i,
   input  logic                bus_fetch_i,
   input  logic                bus_byte_i,
   input  logic [AW-1:0]       bus_addr_i,
   input  logic [15:0]         bus_wdata_i,
   output logic [15:0]         bus_rdata_o,
   output logic                busy_o,
   output logic                wait_o,
   output logic                acc_viol_o,
   input  logic                acc_clr_i
);
   localparam int NSEG      = INFO_SEGS + MAIN_SEGS;
   localparam int SEG_W     = (NSEG > 1) ? $clog2(NSEG) : 1;
   localparam int OFF_W     = $clog2(MAIN_SEG_BYTES / 2);
   localparam int BLK_WORDS = BLK_BYTES / 2;
   localparam int TCNT_W    = $clog2(ERASE_TICKS + 1);
   localparam int BCNT_W    = (BLK_WORDS > 1) ? $clog2(BLK_WORDS) : 1;

   if (ERASE_TICKS < WORD_TICKS || WORD_TICKS <= BLK_TICKS || BLK_TICKS < 1) begin : g_bad_ticks
      $error("tick counts must satisfy ERASE >= WORD > BLK >= 1");
   end
   if (INFO_SEG_BYTES > MAIN_SEG_BYTES || INFO_SEG_BYTES < 4) begin : g_bad_seg
      $error("information segments must be 4..MAIN_SEG_BYTES bytes");
   end
   if (BLK_WORDS < 2) begin : g_bad_blk
      $error("a block needs at least two words");
   end

   // ---------------------------------------------------------------- decode
   logic             b_hit, b_main;
   logic [SEG_W-1:0] b_seg;
   logic [OFF_W-1:0] b_off;

   flashseq_decode #(
      .AW(AW), .INFO_BASE(INFO_BASE), .INFO_SEG_BYTES(INFO_SEG_BYTES),
      .INFO_SEGS(INFO_SEGS), .MAIN_SEG_BYTES(MAIN_SEG_BYTES),
      .MAIN_SEGS(MAIN_SEGS), .SEG_W(SEG_W), .OFF_W(OFF_W)
   ) u_dec (
      .addr(bus_addr_i), .hit(b_hit), .is_main(b_main), .seg(b_seg), .off(b_off)
   );

   // ---------------------------------------------------------------- state
   seq_state_e          state_q;
   logic [CTL_BITS-1:0] ctl_q;
   logic [TCNT_W-1:0]   rem_q;
   logic [BCNT_W-1:0]   bcnt_q;
   logic [SEG_W-1:0]    lat_seg_q;
   logic [OFF_W-1:0]    lat_off_q;
   logic [15:0]         lat_pat_q;
   logic [NSEG-1:0]     emask_q;
   logic                viol_q;

   logic            busy, waiting, counting, tick, last_tick;
   logic            wr_flash, erase_arm, erase_ok, blk_take, blk_stop, viol_ev;
   logic [NSEG-1:0] emask_d;
   logic [15:0]     pat_d;
   logic [15:0]     rd_word;

   assign busy      = (state_q != ST_IDLE);
   assign waiting   = (state_q == ST_BLK_WAIT);
   assign counting  = (state_q == ST_ERASE) || (state_q == ST_WORD) || (state_q == ST_BLK_RUN);
   assign last_tick = tick && (rem_q == TCNT_W'(1));

   flashseq_tickgen #(.DIV_W(DIV_W)) u_tick (
      .clk(clk), .rst_n(rst_n), .en(counting), .div(div_i), .tick(tick)
   );

   assign wr_flash  = bus_req_i && bus_we_i && !bus_fetch_i && b_hit;
   assign erase_arm = ctl_q[CB_ERASE] || ctl_q[CB_MASS];
   assign blk_take  = waiting && wr_flash;
   assign blk_stop  = waiting && ctl_we_i && !(ctl_wdata_i[CB_PROG] && ctl_wdata_i[CB_BLK]);

   // byte lane chosen by address bit0 (R6)
   always_comb begin
      if (!bus_byte_i)
         pat_d = bus_wdata_i;
      else if (bus_addr_i[0])
         pat_d = {bus_wdata_i[7:0], 8'hFF};
      else
         pat_d = {8'hFF, bus_wdata_i[7:0]};
   end

   // erase region from {mass, erase} and the trigger address (R1, R2, R3)
   always_comb begin
      emask_d  = '0;
      erase_ok = 1'b0;
      unique case ({ctl_q[CB_MASS], ctl_q[CB_ERASE]})
         2'b01: begin
            erase_ok = b_hit;
            for (int s = 0; s < NSEG; s++) emask_d[s] = (int'(b_seg) == s);
         end
         2'b10: begin
            erase_ok = b_main;
            for (int s = INFO_SEGS; s < NSEG; s++) emask_d[s] = 1'b1;
         end
         2'b11: begin
            erase_ok = b_hit;
            emask_d  = '1;
         end
         default: ;
      endcase
   end

   // violations: data access while busy, control write while busy and not waiting
   assign viol_ev = (busy && bus_req_i && !bus_fetch_i && b_hit && !blk_take)
                 || (busy && ctl_we_i && !waiting);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         ctl_q     <= '0;
         rem_q     <= '0;
         bcnt_q    <= '0;
         lat_seg_q <= '0;
         lat_off_q <= '0;
         lat_pat_q <= '1;
         emask_q   <= '0;
      end else if (abort_i) begin
         state_q <= ST_IDLE;
         ctl_q   <= '0;
      end else begin
         if (ctl_we_i && (!busy || waiting)) ctl_q <= ctl_wdata_i;
         unique case (state_q)
            ST_IDLE: begin
               if (wr_flash) begin
                  if (erase_arm) begin
                     if (erase_ok) begin
                        state_q <= ST_ERASE;
                        rem_q   <= TCNT_W'(ERASE_TICKS);
                        emask_q <= emask_d;
                     end
                  end else if (ctl_q[CB_PROG]) begin
                     lat_seg_q <= b_seg;
                     lat_off_q <= b_off;
                     lat_pat_q <= pat_d;
                     bcnt_q    <= '0;
                     if (ctl_q[CB_BLK]) begin
                        state_q <= ST_BLK_RUN;
                        rem_q   <= TCNT_W'(BLK_TICKS);
                     end else begin
                        state_q <= ST_WORD;
                        rem_q   <= TCNT_W'(WORD_TICKS);
                     end
                  end
               end
            end
            ST_ERASE: begin
               if (tick) rem_q <= rem_q - 1'b1;
               if (last_tick) begin
                  state_q         <= ST_IDLE;
                  ctl_q[CB_ERASE] <= 1'b0;
                  ctl_q[CB_MASS]  <= 1'b0;
               end
            end
            ST_WORD: begin
               if (tick) rem_q <= rem_q - 1'b1;
               if (last_tick) state_q <= ST_IDLE;
            end
            ST_BLK_RUN: begin
               if (tick) rem_q <= rem_q - 1'b1;
               if (last_tick) begin
                  bcnt_q  <= bcnt_q + 1'b1;
                  state_q <= (bcnt_q == BCNT_W'(BLK_WORDS - 1)) ? ST_IDLE : ST_BLK_WAIT;
               end
            end
            ST_BLK_WAIT: begin
               if (blk_stop) begin
                  state_q <= ST_IDLE;
               end else if (wr_flash) begin
                  lat_seg_q <= b_seg;
                  lat_off_q <= b_off;
                  lat_pat_q <= pat_d;
                  rem_q     <= TCNT_W'(BLK_TICKS);
                  state_q   <= ST_BLK_RUN;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         viol_q <= 1'b0;
      else if (acc_clr_i)
         viol_q <= 1'b0;
      else if (viol_ev)
         viol_q <= 1'b1;
   end

   // ---------------------------------------------------------------- array
   logic erase_go, prog_go;
   assign erase_go = (state_q == ST_ERASE) && last_tick && !abort_i;
   assign prog_go  = ((state_q == ST_WORD) || (state_q == ST_BLK_RUN)) && last_tick && !abort_i;

   flashseq_array #(
      .INFO_SEGS(INFO_SEGS), .INFO_SEG_WORDS(INFO_SEG_BYTES / 2),
      .MAIN_SEGS(MAIN_SEGS), .MAIN_SEG_WORDS(MAIN_SEG_BYTES / 2),
      .SEG_W(SEG_W), .OFF_W(OFF_W)
   ) u_arr (
      .clk(clk), .rst_n(rst_n),
      .erase_go(erase_go), .erase_mask(emask_q),
      .prog_go(prog_go), .prog_seg(lat_seg_q), .prog_off(lat_off_q), .prog_pat(lat_pat_q),
      .rd_seg(b_seg), .rd_off(b_off), .rd_word(rd_word)
   );

   // fetch while busy spins the CPU on a jump-to-self (R8)
   always_comb begin
      if (!b_hit)
         bus_rdata_o = '0;
      else if (busy && bus_fetch_i)
         bus_rdata_o = JMP_SELF;
      else
         bus_rdata_o = rd_word;
   end

   assign ctl_o      = ctl_q;
   assign busy_o     = busy;
   assign wait_o     = waiting;
   assign acc_viol_o = viol_q;

   // ---------------------------------------------------------------- checks
   p_start_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !abort_i && wr_flash && ctl_q[CB_PROG] && !ctl_q[CB_ERASE] && !ctl_q[CB_MASS])
      |=> busy_o);

   p_erase_bits_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy_o) && $past(state_q) == ST_ERASE) |-> (!ctl_o[CB_ERASE] && !ctl_o[CB_MASS]));

   p_fetch_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && bus_req_i && bus_fetch_i && !ctl_we_i && !acc_clr_i && !acc_viol_o)
      |=> !acc_viol_o);

   p_data_viol_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && bus_req_i && !bus_fetch_i && b_hit && !(wait_o && bus_we_i) && !acc_clr_i)
      |=> acc_viol_o);

   p_ctl_viol_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !wait_o && ctl_we_i && !acc_clr_i) |=> acc_viol_o);

   p_abort_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      abort_i |=> (!busy_o && !wait_o && ctl_o == '0));
endmodule

// File: tb/flashseq_ctrl_tb.sv
`timescale 1ns/1ps
module flashseq_ctrl_tb;
   localparam int ERASE_T = 20;
   localparam int WORD_T  = 6;
   localparam int BLK_T   = 3;
   localparam int NBLK    = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  div = '0;
   logic        ctl_we = 1'b0;
   logic [3:0]  ctl_wd = '0;
   logic [3:0]  ctl_rd;
   logic        abort = 1'b0;
   logic        req = 1'b0, we = 1'b0, fetch = 1'b0, bytew = 1'b0;
   logic [15:0] addr = '0, wdata = '0, rdata;
   logic        busy, wt, viol;
   logic        clr = 1'b0;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   flashseq_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .div_i(div),
      .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wd), .ctl_o(ctl_rd), .abort_i(abort),
      .bus_req_i(req), .bus_we_i(we), .bus_fetch_i(fetch), .bus_byte_i(bytew),
      .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
      .busy_o(busy), .wait_o(wt), .acc_viol_o(viol), .acc_clr_i(clr)
   );

   typedef struct packed {
      logic [15:0] a;
      logic [15:0] d;
      logic        b;
      logic [7:0]  dv;
      logic [15:0] exp_w;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VECS [NV] = '{
      '{16'hF800, 16'h1234, 1'b0, 8'd0, 16'h1234},
      '{16'hF800, 16'hFFFF, 1'b0, 8'd1, 16'h1234},
      '{16'hF800, 16'h0F0F, 1'b0, 8'd2, 16'h0204},
      '{16'hF802, 16'h00A5, 1'b1, 8'd3, 16'hFFA5},
      '{16'hF803, 16'h003C, 1'b1, 8'd0, 16'h3CA5},
      '{16'h1000, 16'h8001, 1'b0, 8'd1, 16'h8001},
      '{16'h1001, 16'h0077, 1'b1, 8'd2, 16'h0001},
      '{16'hFFFE, 16'hA5A5, 1'b0, 8'd0, 16'hA5A5}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // all tasks start and end at a falling edge
   task automatic bus_wr(input logic [15:0] a, input logic [15:0] d, input logic b);
      req = 1'b1; we = 1'b1; fetch = 1'b0; bytew = b; addr = a; wdata = d;
      @(negedge clk);
      req = 1'b0; we = 1'b0; bytew = 1'b0;
   endtask

   task automatic bus_rd(input logic [15:0] a, input logic f, output logic [15:0] d);
      req = 1'b1; we = 1'b0; fetch = f; addr = a;
      #1 d = rdata;
      @(negedge clk);
      req = 1'b0; fetch = 1'b0;
   endtask

   task automatic ctl_wr(input logic [3:0] v);
      ctl_we = 1'b1; ctl_wd = v;
      @(negedge clk);
      ctl_we = 1'b0;
   endtask

   task automatic pulse_clr();
      clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
   endtask

   task automatic wait_idle(output int n);
      n = 0;
      while (busy && n < 100000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic wait_blk(output int n);
      n = 0;
      while (busy && !wt && n < 100000) begin
         n++;
         @(negedge clk);
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin : main
      int n;
      logic [15:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R12 reset state
      chk("R12 busy", busy, 0);
      chk("R12 wait", wt, 0);
      chk("R12 viol", viol, 0);
      chk("R12 ctl", ctl_rd, 0);
      bus_rd(16'hF800, 1'b0, r); chk("R12 main word", r, 16'hFFFF);
      bus_rd(16'h1000, 1'b0, r); chk("R12 info word", r, 16'hFFFF);

      // R6/R5 table of programming vectors
      ctl_wr(4'h1);
      for (int i = 0; i < NV; i++) begin
         div = VECS[i].dv;
         bus_wr(VECS[i].a, VECS[i].d, VECS[i].b);
         wait_idle(n);
         chk($sformatf("R5 word duration vec%0d", i), n, WORD_T * (VECS[i].dv + 1));
         bus_rd(VECS[i].a, 1'b0, r);
         chk($sformatf("R6 readback vec%0d", i), r, VECS[i].exp_w);
      end
      chk("R5 write bit kept", ctl_rd, 4'h1);

      // R1 segment erase from odd address in main segment 0
      div = 8'd1;
      ctl_wr(4'h4);
      bus_wr(16'hF801, 16'h0000, 1'b0);
      chk("R5 busy at start", busy, 1);
      wait_idle(n);
      chk("R5 erase duration", n, ERASE_T * 2);
      chk("R5 erase bit cleared", ctl_rd, 4'h0);
      bus_rd(16'hF800, 1'b0, r); chk("R1 seg word0", r, 16'hFFFF);
      bus_rd(16'hF802, 1'b0, r); chk("R1 seg word1", r, 16'hFFFF);
      bus_rd(16'hFFFE, 1'b0, r); chk("R1 other main seg", r, 16'hA5A5);
      bus_rd(16'h1000, 1'b0, r); chk("R1 info seg", r, 16'h0001);

      // R4 trigger outside flash is ignored
      div = 8'd0;
      ctl_wr(4'h4);
      bus_wr(16'h0200, 16'h0000, 1'b0);
      chk("R4 no busy", busy, 0);
      chk("R4 ctl kept", ctl_rd, 4'h4);

      // R2 main-only erase
      ctl_wr(4'h1);
      bus_wr(16'h1080, 16'h1111, 1'b0);
      wait_idle(n);
      ctl_wr(4'h8);
      bus_wr(16'h1000, 16'h0000, 1'b0);
      chk("R2 info trigger ignored", busy, 0);
      chk("R2 ctl kept", ctl_rd, 4'h8);
      bus_wr(16'hF900, 16'h0000, 1'b0);
      wait_idle(n);
      chk("R2 duration", n, ERASE_T);
      bus_rd(16'hFFFE, 1'b0, r); chk("R2 main erased", r, 16'hFFFF);
      bus_rd(16'h1000, 1'b0, r); chk("R2 info0 kept", r, 16'h0001);
      bus_rd(16'h1080, 1'b0, r); chk("R2 info1 kept", r, 16'h1111);
      chk("R2 mass bit cleared", ctl_rd, 4'h0);

      // R3 full erase from an info address
      ctl_wr(4'hC);
      bus_wr(16'h1080, 16'h0000, 1'b0);
      wait_idle(n);
      bus_rd(16'h1000, 1'b0, r); chk("R3 info0 erased", r, 16'hFFFF);
      bus_rd(16'h1080, 1'b0, r); chk("R3 info1 erased", r, 16'hFFFF);
      chk("R3 bits cleared", ctl_rd, 4'h0);

      // R8/R9/R10 accesses during an erase
      ctl_wr(4'h1);
      bus_wr(16'hF800, 16'h0000, 1'b0);
      wait_idle(n);
      bus_rd(16'hF800, 1'b0, r); chk("R6 programmed zero", r, 16'h0000);
      div = 8'd3;
      ctl_wr(4'h4);
      bus_wr(16'hF800, 16'h0000, 1'b0);
      bus_rd(16'hF800, 1'b1, r); chk("R8 fetch opcode", r, 16'h3FFF);
      chk("R8 no violation", viol, 0);
      bus_wr(16'hF800, 16'h1234, 1'b0);
      chk("R9 write violation", viol, 1);
      chk("R9 still busy", busy, 1);
      pulse_clr();
      chk("R9 flag cleared", viol, 0);
      ctl_wr(4'h1);
      chk("R10 ctl violation", viol, 1);
      chk("R10 ctl unchanged", ctl_rd, 4'h4);
      pulse_clr();
      bus_rd(16'hF802, 1'b0, r);
      chk("R9 read violation", viol, 1);
      pulse_clr();
      wait_idle(n);
      bus_rd(16'hF800, 1'b0, r); chk("R9 erase completed, write dropped", r, 16'hFFFF);

      // R11 abort of a word write
      div = 8'd0;
      ctl_wr(4'h1);
      bus_wr(16'hF804, 16'h0000, 1'b0);
      @(negedge clk);
      abort = 1'b1;
      @(negedge clk);
      abort = 1'b0;
      chk("R11 busy low", busy, 0);
      chk("R11 wait low", wt, 0);
      chk("R11 ctl cleared", ctl_rd, 4'h0);
      repeat (WORD_T) @(negedge clk);
      bus_rd(16'hF804, 1'b0, r); chk("R11 array unchanged", r, 16'hFFFF);

      // R7 full block run
      ctl_wr(4'h3);
      for (int i = 0; i < NBLK; i++) begin
         bus_wr(16'hF900 + 16'(2 * i), 16'h0100 + 16'(i), 1'b0);
         if (i == 0) chk("R7 wait low during word", wt, 0);
         wait_blk(n);
         if (i == 0 || i == NBLK - 1)
            chk($sformatf("R7 block word %0d duration", i), n, BLK_T);
      end
      chk("R7 busy ends after last word", busy, 0);
      chk("R7 wait low at end", wt, 0);
      chk("R7 no violation", viol, 0);
      bus_rd(16'hF90A, 1'b0, r); chk("R7 word5", r, 16'h0105);
      bus_rd(16'hF93E, 1'b0, r); chk("R7 word31", r, 16'h011F);

      // R7 early end by clearing the write bit while waiting
      bus_wr(16'hFA00, 16'h0000, 1'b0);
      wait_blk(n);
      chk("R7 wait high", wt, 1);
      ctl_wr(4'h0);
      chk("R7 early stop busy", busy, 0);
      chk("R7 early stop no violation", viol, 0);
      bus_rd(16'hFA00, 1'b0, r); chk("R7 early word", r, 16'h0000);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule